// File: doc/BRIEF.md
# Three-Form Instruction Decoder

This block takes the two bytes of a 16-bit base instruction, as the fetch path delivers them, and turns them into decoded fields for an execute stage. The top two bits of the word pick one of three layouts: a register form with an 8-bit opcode and two 4-bit register indices, a short-immediate form with a 2-bit opcode, one register and an 8-bit constant, and a branch form with a 4-bit condition opcode and a 10-bit halfword offset. Instruction fetch, execution and register-file reads are handled by other blocks.

Along with the fields, the decoder states how long the whole instruction is. A register-form opcode may be followed by a 32-bit extension word, which gives 6 bytes, or by a 16-bit signed displacement, which gives 4 bytes. Every other instruction is 2 bytes long. The block also flags opcodes that are not defined and gives a one-hot operation class that the execute stage can use for dispatch.

The decode logic is purely combinational. A parameter `REG_OUT` places a one-stage output register with a valid bit behind it, or removes that register. The module has no state machine. The only sequential element is that optional register, which either loads or holds, and it is cleared by reset.

Top module: `instr_decoder`

## Requirements
- R1: The instruction word is `{fetch_b0, fetch_b1}`. `fetch_b0` is the byte at the lower address and forms bits 15:8.
- R2: `fmt` is 0 (register form) when bit 15 is clear, 1 (short-immediate form) when bits 15:14 are 2'b10, and 2 (branch form) when bits 15:14 are 2'b11.
- R3: In branch form, `opcode` is bits 13:10 zero-extended, and `disp` is the 10-bit offset in bits 9:0, sign-extended to 32 bits and multiplied by two. `reg_a`, `reg_b` and `imm8` are zero.
- R4: A branch-form opcode greater than 9 sets `illegal`.
- R5: In short-immediate form, `opcode` is bits 13:12, `reg_a` is bits 11:8 and `imm8` is bits 7:0. `reg_b` and `disp` are zero. Opcodes 0 and 1 (add and subtract constant) are ALU class. Opcodes 2 and 3 (special-register read and write) are special class.
- R6: In register form, `opcode` is bits 15:8, `reg_a` is bits 7:4 and `reg_b` is bits 3:0. `imm8` and `disp` are zero.
- R7: Register-form opcodes 0x01, 0x03, 0x08, 0x09, 0x1a, 0x1b, 0x1d, 0x1f, 0x20, 0x22, 0x24 and 0x30 set `ext32` and report `len` = 6.
- R8: Register-form opcodes 0x0c, 0x0d and 0x36 to 0x39 set `ext16` and report `len` = 4.
- R9: All other instructions, including every branch-form and short-immediate word, report `len` = 2 with both extension flags clear.
- R10: Register-form opcodes 0x00, 0x0f, 0x16 to 0x18 and everything above 0x39 are illegal. An illegal instruction has `op_class` = 0, `len` = 2 and no extension flag.
- R11: `op_class` is one-hot for legal instructions. The bits are: bit 0 ALU, bit 1 load, bit 2 store, bit 3 branch, bit 4 call, bit 5 special.
  - Load: 0x07, 0x08, 0x0a, 0x0c, 0x1c, 0x1d, 0x21, 0x22, 0x36, 0x38.
  - Store: 0x06, 0x09, 0x0b, 0x0d, 0x1e, 0x1f, 0x23, 0x24, 0x37, 0x39.
  - Branch: 0x1a, 0x25 and every legal branch-form word.
  - Call: 0x03, 0x04, 0x19.
  - Special: 0x30, 0x35.
  - ALU: all other legal register-form opcodes.
- R12: With `REG_OUT`=1, the decode of a word presented with `in_valid` appears on the outputs with `out_valid` high one clock later. A cycle without `in_valid` drops `out_valid` and leaves the decoded outputs unchanged. Reset clears `out_valid` and every decoded output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The fetch bytes hold an instruction |
| fetch_b0 | input | 8 | Byte at the lower address (word bits 15:8) |
| fetch_b1 | input | 8 | Byte at the higher address (word bits 7:0) |
| out_valid | output | 1 | Decoded outputs are valid |
| fmt | output | 2 | Layout: 0 register, 1 short-immediate, 2 branch |
| opcode | output | 8 | Opcode, zero-extended |
| reg_a | output | 4 | First register index |
| reg_b | output | 4 | Second register index |
| imm8 | output | 8 | Short-immediate constant |
| disp | output | 32 | Branch byte displacement, sign-extended |
| len | output | 3 | Instruction length in bytes (2, 4 or 6) |
| ext32 | output | 1 | A 32-bit extension word follows |
| ext16 | output | 1 | A 16-bit displacement follows |
| illegal | output | 1 | Undefined opcode |
| op_class | output | 6 | One-hot operation class |

## Verification
The cases that are hardest to reach are the edges of the opcode map: the holes at 0x0f and 0x16 to 0x18, the first undefined value 0x3a, and branch opcodes 10 to 15. A single reused opcode would never land on any of them. The stimulus therefore sweeps every register-form opcode from 0x00 to 0x7f and every branch opcode with offsets at zero, at both signed extremes and at -1. Each expected item is queued from a model of the requirements and compared when the registered result emerges. The hold behaviour is checked separately by driving new bytes with `in_valid` low and confirming that the outputs keep the previous decode.

// File: rtl/idec_pkg.sv
package idec_pkg;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int OFF_W   = 10;
    localparam int DISP_W  = 32;
    localparam int CLASS_N = 6;
    localparam int LEN_W   = 3;

    localparam int CL_ALU   = 0;
    localparam int CL_LOAD  = 1;
    localparam int CL_STORE = 2;
    localparam int CL_BR    = 3;
    localparam int CL_CALL  = 4;
    localparam int CL_SPEC  = 5;

    localparam logic [3:0] BR_OP_MAX = 4'd9;

    typedef enum logic [1:0] {
        FMT_REG  = 2'd0,
        FMT_SIMM = 2'd1,
        FMT_BR   = 2'd2
    } fmt_e;

    typedef struct packed {
        fmt_e                fmt;
        logic [7:0]          opcode;
        logic [3:0]          reg_a;
        logic [3:0]          reg_b;
        logic [7:0]          imm8;
        logic [DISP_W-1:0]   disp;
        logic [LEN_W-1:0]    len;
        logic                ext32;
        logic                ext16;
        logic                illegal;
        logic [CLASS_N-1:0]  op_class;
    } dec_t;
endpackage

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fmt_e              fmt,
    output logic [7:0]        opcode,
    output logic [3:0]        reg_a,
    output logic [3:0]        reg_b,
    output logic [7:0]        imm8,
    output logic [DISP_W-1:0] disp
);
    localparam int SEXT_W = DISP_W - OFF_W - 1;

    always_comb begin
        opcode = '0;
        reg_a  = '0;
        reg_b  = '0;
        imm8   = '0;
        disp   = '0;
        unique case (word[15:14])
            2'b11: begin
                fmt    = FMT_BR;
                opcode = {4'd0, word[13:10]};
                disp   = {{SEXT_W{word[OFF_W-1]}}, word[OFF_W-1:0], 1'b0};
            end
            2'b10: begin
                fmt    = FMT_SIMM;
                opcode = {6'd0, word[13:12]};
                reg_a  = word[11:8];
                imm8   = word[7:0];
            end
            default: begin
                fmt    = FMT_REG;
                opcode = word[15:8];
                reg_a  = word[7:4];
                reg_b  = word[3:0];
            end
        endcase
    end
endmodule

// File: rtl/idec_opinfo.sv
module idec_opinfo
    import idec_pkg::*;
(
    input  logic [7:0]         op,
    output logic               ext32,
    output logic               ext16,
    output logic               bad,
    output logic [CLASS_N-1:0] cls
);
    always_comb begin
        ext32 = 1'b0;
        ext16 = 1'b0;
        bad   = 1'b0;
        cls   = '0;

        case (op) inside
            8'h01, 8'h03, 8'h08, 8'h09, 8'h1a, 8'h1b,
            8'h1d, 8'h1f, 8'h20, 8'h22, 8'h24, 8'h30: ext32 = 1'b1;
            8'h0c, 8'h0d, [8'h36:8'h39]:                ext16 = 1'b1;
            default: ;
        endcase

        case (op) inside
            8'h00, 8'h0f, [8'h16:8'h18], [8'h3a:8'hff]: bad = 1'b1;
            8'h07, 8'h08, 8'h0a, 8'h0c, 8'h1c, 8'h1d,
            8'h21, 8'h22, 8'h36, 8'h38:                 cls[CL_LOAD]  = 1'b1;
            8'h06, 8'h09, 8'h0b, 8'h0d, 8'h1e, 8'h1f,
            8'h23, 8'h24, 8'h37, 8'h39:                 cls[CL_STORE] = 1'b1;
            8'h1a, 8'h25:                               cls[CL_BR]    = 1'b1;
            8'h03, 8'h04, 8'h19:                        cls[CL_CALL]  = 1'b1;
            8'h30, 8'h35:                               cls[CL_SPEC]  = 1'b1;
            default:                                    cls[CL_ALU]   = 1'b1;
        endcase

        if (bad) begin
            ext32 = 1'b0;
            ext16 = 1'b0;
        end
    end
endmodule

// File: rtl/idec_outreg.sv
module idec_outreg
    import idec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  dec_t d,
    output logic out_valid,
    output dec_t q
);
    generate
        if (REG_OUT) begin : g_reg
            dec_t q_r;
            logic v_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_r <= '0;
                    v_r <= 1'b0;
                end else begin
                    v_r <= in_valid;
                    if (in_valid) q_r <= d;
                end
            end
            assign q         = q_r;
            assign out_valid = v_r;
        end else begin : g_comb
            assign q         = d;
            assign out_valid = in_valid;
        end
    endgenerate
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
    import idec_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  fetch_b0,
    input  logic [BYTE_W-1:0]  fetch_b1,
    output logic               out_valid,
    output logic [1:0]         fmt,
    output logic [7:0]         opcode,
    output logic [3:0]         reg_a,
    output logic [3:0]         reg_b,
    output logic [7:0]         imm8,
    output logic [DISP_W-1:0]  disp,
    output logic [LEN_W-1:0]   len,
    output logic               ext32,
    output logic               ext16,
    output logic               illegal,
    output logic [CLASS_N-1:0] op_class
);
    logic [WORD_W-1:0]  word;
    fmt_e               f_fmt;
    logic [7:0]         f_op;
    logic [3:0]         f_ra, f_rb;
    logic [7:0]         f_imm;
    logic [DISP_W-1:0]  f_disp;
    logic               i_e32, i_e16, i_bad;
    logic [CLASS_N-1:0] i_cls;
    dec_t               dec_d, dec_q;

    assign word = {fetch_b0, fetch_b1};

    idec_fields u_fields (
        .word   (word),
        .fmt    (f_fmt),
        .opcode (f_op),
        .reg_a  (f_ra),
        .reg_b  (f_rb),
        .imm8   (f_imm),
        .disp   (f_disp)
    );

    idec_opinfo u_opinfo (
        .op    (f_op),
        .ext32 (i_e32),
        .ext16 (i_e16),
        .bad   (i_bad),
        .cls   (i_cls)
    );

    always_comb begin
        dec_d        = '0;
        dec_d.fmt    = f_fmt;
        dec_d.opcode = f_op;
        dec_d.reg_a  = f_ra;
        dec_d.reg_b  = f_rb;
        dec_d.imm8   = f_imm;
        dec_d.disp   = f_disp;
        unique case (f_fmt)
            FMT_BR: begin
                dec_d.illegal = (f_op[3:0] > BR_OP_MAX);
                dec_d.op_class[CL_BR] = ~dec_d.illegal;
            end
            FMT_SIMM: begin
                if (f_op[1]) dec_d.op_class[CL_SPEC] = 1'b1;
                else         dec_d.op_class[CL_ALU]  = 1'b1;
            end
            default: begin
                dec_d.ext32    = i_e32;
                dec_d.ext16    = i_e16;
                dec_d.illegal  = i_bad;
                dec_d.op_class = i_bad ? '0 : i_cls;
            end
        endcase
        dec_d.len = dec_d.ext32 ? LEN_W'(6) : (dec_d.ext16 ? LEN_W'(4) : LEN_W'(2));
    end

    idec_outreg #(.REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d         (dec_d),
        .out_valid (out_valid),
        .q         (dec_q)
    );

    assign fmt      = dec_q.fmt;
    assign opcode   = dec_q.opcode;
    assign reg_a    = dec_q.reg_a;
    assign reg_b    = dec_q.reg_b;
    assign imm8     = dec_q.imm8;
    assign disp     = dec_q.disp;
    assign len      = dec_q.len;
    assign ext32    = dec_q.ext32;
    assign ext16    = dec_q.ext16;
    assign illegal  = dec_q.illegal;
    assign op_class = dec_q.op_class;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid,
    input logic [1:0] fmt,
    input logic [7:0] opcode,
    input logic [2:0] len,
    input logic       ext32,
    input logic       ext16,
    input logic       illegal,
    input logic [5:0] op_class
);
    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(op_class)); // R11

    AST_LEGAL_HAS_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !illegal) |-> $countones(op_class) == 1); // R11

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> (op_class == 6'd0 && !ext32 && !ext16 && len == 3'd2)); // R10

    AST_EXT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(ext32 && ext16)); // R7

    AST_BRANCH_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fmt == 2'd2) |-> (len == 3'd2 && !ext32 && !ext16)); // R9

    AST_BRANCH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fmt == 2'd2 && opcode > 8'd9) |-> illegal); // R4
endmodule

bind instr_decoder instr_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .fmt       (fmt),
    .opcode    (opcode),
    .len       (len),
    .ext32     (ext32),
    .ext16     (ext16),
    .illegal   (illegal),
    .op_class  (op_class)
);

// File: tb/sim_instr_decoder.sv
`timescale 1ns/1ps
module sim_instr_decoder;
    import idec_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  fetch_b0 = '0, fetch_b1 = '0;
    logic        out_valid;
    logic [1:0]  fmt;
    logic [7:0]  opcode;
    logic [3:0]  reg_a, reg_b;
    logic [7:0]  imm8;
    logic [31:0] disp;
    logic [2:0]  len;
    logic        ext32, ext16, illegal;
    logic [5:0]  op_class;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    dec_t expq[$];
    dec_t last_exp;

    always #5 clk = ~clk;

    instr_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .fetch_b0(fetch_b0), .fetch_b1(fetch_b1),
        .out_valid(out_valid), .fmt(fmt), .opcode(opcode),
        .reg_a(reg_a), .reg_b(reg_b), .imm8(imm8), .disp(disp),
        .len(len), .ext32(ext32), .ext16(ext16), .illegal(illegal),
        .op_class(op_class)
    );

    function automatic dec_t actual();
        dec_t a;
        a.fmt = fmt_e'(fmt); a.opcode = opcode; a.reg_a = reg_a; a.reg_b = reg_b;
        a.imm8 = imm8; a.disp = disp; a.len = len; a.ext32 = ext32;
        a.ext16 = ext16; a.illegal = illegal; a.op_class = op_class;
        return a;
    endfunction

    // Reference model written from the requirements
    function automatic dec_t model(input logic [7:0] hi, input logic [7:0] lo);
        dec_t e = '0;
        logic [7:0] op;
        e.len = 3'd2;
        if (hi[7] && hi[6]) begin                         // R2, R3, R4
            e.fmt = FMT_BR;
            e.opcode = {4'd0, hi[5:2]};
            e.disp = 32'($signed({hi[1:0], lo})) * 2;
            e.illegal = (hi[5:2] > 4'd9);
            e.op_class = e.illegal ? 6'b0 : 6'b001000;
        end else if (hi[7]) begin                         // R5
            e.fmt = FMT_SIMM;
            e.opcode = {6'd0, hi[5:4]};
            e.reg_a = hi[3:0];
            e.imm8 = lo;
            e.op_class = (hi[5:4] >= 2'd2) ? 6'b100000 : 6'b000001;
        end else begin                                    // R6
            op = hi;
            e.fmt = FMT_REG;
            e.opcode = op;
            e.reg_a = lo[7:4];
            e.reg_b = lo[3:0];
            e.illegal = (op == 8'h00) || (op == 8'h0f) || (op >= 8'h16 && op <= 8'h18) || (op > 8'h39);
            if (!e.illegal) begin
                e.ext32 = op inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h1a, 8'h1b,
                                     8'h1d, 8'h1f, 8'h20, 8'h22, 8'h24, 8'h30};
                e.ext16 = op inside {8'h0c, 8'h0d, 8'h36, 8'h37, 8'h38, 8'h39};
                if (e.ext32) e.len = 3'd6;
                else if (e.ext16) e.len = 3'd4;
                if (op inside {8'h07, 8'h08, 8'h0a, 8'h0c, 8'h1c, 8'h1d, 8'h21, 8'h22, 8'h36, 8'h38})
                    e.op_class = 6'b000010;
                else if (op inside {8'h06, 8'h09, 8'h0b, 8'h0d, 8'h1e, 8'h1f, 8'h23, 8'h24, 8'h37, 8'h39})
                    e.op_class = 6'b000100;
                else if (op inside {8'h1a, 8'h25})
                    e.op_class = 6'b001000;
                else if (op inside {8'h03, 8'h04, 8'h19})
                    e.op_class = 6'b010000;
                else if (op inside {8'h30, 8'h35})
                    e.op_class = 6'b100000;
                else
                    e.op_class = 6'b000001;
            end
        end
        return e;
    endfunction

    function automatic string req_of(input dec_t e);
        if (e.illegal)               return "R10/R4";
        if (e.fmt == FMT_BR)         return "R3";
        if (e.fmt == FMT_SIMM)       return "R5";
        if (e.ext32)                 return "R7";
        if (e.ext16)                 return "R8";
        return "R6/R9/R11";
    endfunction

    task automatic report_summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic drive(input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk);
        fetch_b0 = hi;
        fetch_b1 = lo;
        in_valid = 1'b1;
        expq.push_back(model(hi, lo));
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: compares each registered result with the queued expectation (R1, R12)
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            dec_t a, e;
            a = actual();
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL R12: out_valid with no pending item, actual=%h expected=none", a);
            end else begin
                e = expq.pop_front();
                last_exp = e;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s: word=%h actual=%h expected=%h", req_of(e),
                             {e.opcode, e.reg_a, e.reg_b}, a, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report_summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        checks++;
        if (out_valid !== 1'b0 || actual() !== dec_t'('0)) begin
            errors++;
            $display("FAIL R12: reset state actual=%b/%h expected=0/0", out_valid, actual());
        end
        rst_n = 1'b1;

        // R1: byte order, mov r3<-r5 style word
        drive(8'h02, 8'h35);
        // R6-R11: full register-form opcode sweep, varied register fields
        for (int op = 0; op < 128; op++)
            drive(8'(op), 8'((op * 37 + 11) & 8'hff));
        // R3, R4: every branch opcode with offset extremes
        for (int bop = 0; bop < 16; bop++) begin
            drive({2'b11, 4'(bop), 2'b00}, 8'h00);
            drive({2'b11, 4'(bop), 2'b01}, 8'hff);
            drive({2'b11, 4'(bop), 2'b10}, 8'h00);
            drive({2'b11, 4'(bop), 2'b11}, 8'hff);
        end
        // R5: short-immediate opcodes
        for (int sop = 0; sop < 4; sop++) begin
            drive({2'b10, 2'(sop), 4'(sop + 9)}, 8'(8'hff - sop));
            drive({2'b10, 2'(sop), 4'd0}, 8'h00);
        end
        go_idle();
        @(negedge clk);

        // R12: idle cycle holds outputs, out_valid low
        drive(8'h2b, 8'h7e);
        @(negedge clk);
        in_valid = 1'b0;
        fetch_b0 = 8'hc0;
        fetch_b1 = 8'h01;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || actual() !== last_exp) begin
            errors++;
            $display("FAIL R12: hold actual=%b/%h expected=0/%h", out_valid, actual(), last_exp);
        end

        repeat (2) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R12: pending items actual=%0d expected=0", expq.size());
        end
        done = 1'b1;
        report_summary();
    end
endmodule